// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM with Selectable Read Latency

A small synchronous static memory whose word is divided into byte lanes (four lanes of nine bits by default). Address, the three chip selects, the write controls and the write data are all captured on the rising clock edge. Output enable and sleep act on the output drive without waiting for a clock. Instead of a tristate bus, the block presents a read-data bus together with a drive-enable flag. The data bus reads zero whenever the flag is low.

A mode input chooses between two read latencies, and it may change at run time. In flow-through mode the word addressed by the registered read appears in the cycle that follows the capturing edge. In pipelined mode the word first passes through an output register, so it appears one cycle later. Writes can cover selected lanes under the byte-write enable, or all lanes under the global write. The sleep input freezes the command path and stops the output drive, and the stored contents are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: A command is accepted only when cs1_n=0, cs2=1 and cs3_n=0 all hold at the clock edge. Otherwise the edge counts as a deselect: nothing is written and no read is started.
- R2: With pipe_sel=0 (flow-through), a read registered at edge k drives rdata_oe=1 and rdata equal to the stored word from just after edge k until edge k+1.
- R3: With pipe_sel=1 (pipelined), a read registered at edge k drives the word that was stored at edge k+1, from just after edge k+1 until edge k+2. Between edges k and k+1 that read does not drive.
- R4: With bw_n=0 and gw_n=1, exactly the lanes i with lane_n[i]=0 are written, lane i being wdata bits [9i+8:9i]. The other lanes keep their contents. bw_n=0 with every lane_n bit high is a read.
- R5: gw_n=0 writes all lanes from wdata, whatever the values of bw_n and lane_n.
- R6: Single-cycle deselect: after a deselect is registered, the output stops driving at the first cycle boundary in which no registered read is pending for the current mode.
- R7: oe_n=1 forces rdata_oe=0 and rdata=0 at once, without waiting for a clock edge. Returning oe_n to 0 restores the pending read output.
- R8: While sleep=1, writes and reads are ignored and the output is not driven. Memory contents survive sleep.
- R9: A write cycle, or reset (rst_n=0), leaves the output undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| addr | input | ADDR_W | Word address |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| wdata | input | LANES*LANE_W | Write data |
| pipe_sel | input | 1 | 1 = pipelined reads, 0 = flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power hold, active high |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
Two things can land in the same cycle: a pipelined read beat leaving the output register, and a write or deselect registered at the same edge. Likewise, a flow-through read can be pending while the same address is written at the next edge. The random phase keeps addresses in a narrow range and mixes reads, lane writes, global writes, bad chip selects, mode flips, sleep and output-enable pulses. Every cycle is compared with a bench reference model, so these overlaps are judged on the output. Directed cases cover each chip select alone, sleep with a write attempt, and output enable toggled mid-cycle.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    bw_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    gw_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    pipe_sel,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              sel, wr_go, rd_go;
  logic [LANES-1:0]  wr_lanes;
  logic [WORD_W-1:0] bit_mask, cur_word, ra_word, pipe_q;
  logic [ADDR_W-1:0] ra;
  logic              rd_act, pipe_act, src_act;

  assign sel      = !cs1_n && cs2 && !cs3_n;
  assign wr_lanes = !gw_n ? {LANES{1'b1}} : (bw_n ? '0 : ~lane_n);
  assign wr_go    = sel && !sleep && (|wr_lanes);
  assign rd_go    = sel && !sleep && !(|wr_lanes);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk)
      if (wr_go && wr_lanes[i]) bank[addr] <= wdata[i*LANE_W +: LANE_W];
    assign cur_word[i*LANE_W +: LANE_W] = bank[addr];
    assign ra_word[i*LANE_W +: LANE_W]  = bank[ra];
    assign bit_mask[i*LANE_W +: LANE_W] = {LANE_W{wr_lanes[i]}};
  end

  always_ff @(posedge clk) begin
    ra     <= addr;
    pipe_q <= ra_word;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_act   <= 1'b0;
      pipe_act <= 1'b0;
    end else begin
      rd_act   <= rd_go;
      pipe_act <= rd_act;
    end

  assign src_act  = pipe_sel ? pipe_act : rd_act;
  assign rdata_oe = src_act && !oe_n && !sleep;
  assign rdata    = rdata_oe ? (pipe_sel ? pipe_q : ra_word) : '0;

  p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rd_act);

  p_pipe_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> (pipe_act && pipe_q == $past(ra_word)));

  p_lane_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && gw_n) |=> ((ra_word & ~$past(bit_mask)) == ($past(cur_word) & ~$past(bit_mask))
                        && (ra_word & $past(bit_mask)) == ($past(wdata) & $past(bit_mask))));

  p_global_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sleep && !gw_n) |=> ra_word == $past(wdata));

  p_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe && rdata == '0);

  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_act && $stable(cur_word) || !$stable(addr));
endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
  localparam int AW = 6, LN = 4, LW = 9, WW = LN * LW, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic cs1_n = 1, cs2 = 0, cs3_n = 1, bw_n = 1, gw_n = 1;
  logic [LN-1:0] lane_n = '1;
  logic [WW-1:0] wdata = '0;
  logic pipe_sel = 0, oe_n = 0, sleep = 0;
  logic [WW-1:0] rdata;
  logic rdata_oe;

  sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [WW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] m_ra = '0;
  logic m_act = 0, m_pact = 0;
  logic [WW-1:0] m_pdata = '0;

  function automatic logic [WW-1:0] lane_mask(logic g, logic b, logic [LN-1:0] l);
    logic [WW-1:0] m = '0;
    for (int i = 0; i < LN; i++)
      if (!g || (!b && !l[i])) m[i*LW +: LW] = '1;
    return m;
  endfunction

  task automatic model_edge();
    logic s = !cs1_n && cs2 && !cs3_n && !sleep;
    logic [WW-1:0] m = lane_mask(gw_n, bw_n, lane_n);
    m_pdata = ref_mem[m_ra];
    m_pact  = m_act;
    if (s && m != '0) ref_mem[addr] = (ref_mem[addr] & ~m) | (wdata & m);
    m_act = s && (m == '0);
    m_ra  = addr;
    if (!rst_n) begin m_act = 0; m_pact = 0; end
  endtask

  task automatic compare(string req);
    logic e_oe = (pipe_sel ? m_pact : m_act) && !oe_n && !sleep;
    logic [WW-1:0] e_d = e_oe ? (pipe_sel ? m_pdata : ref_mem[m_ra]) : '0;
    checks++;
    if (rdata_oe !== e_oe || rdata !== e_d) begin
      errors++;
      $display("FAIL %s t=%0t oe act=%b exp=%b data act=%h exp=%h", req, $time,
               rdata_oe, e_oe, rdata, e_d);
    end
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle();
    cs1_n = 1; cs2 = 0; cs3_n = 1; bw_n = 1; gw_n = 1; lane_n = '1;
  endtask

  task automatic cmd(logic [AW-1:0] a, logic g, logic b, logic [LN-1:0] l, logic [WW-1:0] d);
    cs1_n = 0; cs2 = 1; cs3_n = 0; addr = a; gw_n = g; bw_n = b; lane_n = l; wdata = d;
  endtask

  function automatic string rtag();
    if (sleep) return "R8";
    if (oe_n) return "R7";
    return pipe_sel ? "R3" : "R2";
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    tick("R9"); tick("R9");
    rst_n = 1;
    // R5 fill every word with global write
    for (int a = 0; a < DEPTH; a++) begin
      cmd(a[AW-1:0], 0, 1, '1, {$urandom, $urandom} & {WW{1'b1}});
      tick("R9");
    end
    // R2 flow-through read
    pipe_sel = 0; cmd(5, 1, 1, '1, '0); tick("R2");
    idle(); tick("R6");
    // R3 pipelined read: silent first, then drive
    pipe_sel = 1; cmd(7, 1, 1, '1, '0); tick("R3");
    idle(); tick("R3"); tick("R6");
    // R4 partial lane write, then read back; bw with no lanes reads
    pipe_sel = 0;
    cmd(9, 1, 0, 4'b1010, 36'h1_2345_6789); tick("R4");
    cmd(9, 1, 0, 4'b1111, 36'h0); tick("R4");
    idle(); tick("R4");
    // R5 global write overrides inactive byte controls
    cmd(9, 0, 1, 4'b1111, 36'hA_BCDE_F012); tick("R5");
    cmd(9, 1, 1, '1, '0); tick("R5");
    // R1 each chip select wrong alone
    cmd(9, 1, 1, '1, '0); cs1_n = 1; tick("R1");
    cmd(9, 1, 1, '1, '0); cs2 = 0; tick("R1");
    cmd(9, 1, 1, '1, '0); cs3_n = 1; tick("R1");
    cmd(9, 0, 1, '1, '1); cs2 = 0; tick("R1");
    cmd(9, 1, 1, '1, '0); tick("R1");
    // R6 pipelined read followed by deselect
    pipe_sel = 1; tick("R6");
    idle(); tick("R6"); tick("R6"); tick("R6");
    // R8 sleep blocks write and read, contents survive
    sleep = 1; cmd(9, 0, 1, '1, '0); tick("R8");
    cmd(9, 1, 1, '1, '0); tick("R8"); tick("R8");
    sleep = 0; pipe_sel = 0; tick("R8");
    // R7 oe_n asynchronous within a cycle
    cmd(9, 1, 1, '1, '0); tick("R7");
    oe_n = 1; #0.5 compare("R7");
    oe_n = 0; #0.5 compare("R7");
    // R9 write cycle does not drive
    cmd(3, 0, 1, '1, 36'h5); tick("R9");
    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      cmd($urandom_range(0, 7), ($urandom_range(0, 99) < 15) ? 1'b0 : 1'b1,
          ($urandom_range(0, 99) < 35) ? 1'b0 : 1'b1, $urandom,
          {$urandom, $urandom} & {WW{1'b1}});
      if (r < 8) cs1_n = 1; else if (r < 14) cs2 = 0; else if (r < 20) cs3_n = 1;
      sleep = ($urandom_range(0, 99) < 5);
      oe_n  = ($urandom_range(0, 99) < 10);
      if (n % 250 == 0) pipe_sel = ~pipe_sel;
      tick(rtag());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule